// File: doc/BRIEF.md
# Nonvolatile SRAM Command Sequencer

This block is the control layer between a host's SRAM-style bus and a register model of an SRAM array that has a nonvolatile shadow copy. The host drives chip enable, write enable, output enable, an address and write data. The bus is sampled on every clock, and each clock with chip enable low is one access. Ordinary reads and writes go to the array. Two fixed runs of six read addresses are also recognised as commands: one turns automatic saving off and the other turns it back on. The matched reads still return normal array data.

A manual save copies the array and the automatic-save flag into the shadow. A restore first clears the array and then copies the shadow into it. A power-up event runs a restore and also reloads the automatic-save flag from the shadow. While a save or restore runs, a busy output is high and host accesses are ignored. A low-supply input blocks writes and externally requested saves. If chip enable and write enable are both low at reset release, or when a save or restore finishes, writes stay blocked until one of those two enables falls.

Top module: `nvs_seq_top`

## Requirements
- R1: After reset the automatic-save flag `auto_en` is 1, `busy` is 0, `rvalid` is 0, and every array word reads as zero.
- R2: Six consecutive accepted reads whose low 16 address bits are 0x4E38, 0xB1C7, 0x83E0, 0x7C1F, 0x703F and 0x8B45 clear `auto_en` at the clock edge that accepts the sixth read. Each of those reads still returns the array word at its address.
- R3: The same first five addresses followed by a read at 0x4B46 set `auto_en` at the edge that accepts the sixth read.
- R4: A read that does not match the next expected address restarts the matcher. If that read is at 0x4E38, it counts as the first step of a new run. Any write attempt also restarts the matcher.
- R5: Only the low 16 address bits are compared, so a run with upper address bits set is still recognised.
- R6: A one-cycle `pwr_up` pulse starts a restore and loads `auto_en` from the flag that the last save stored in the shadow. The shadow flag is 1 after reset.
- R7: A restore (from `restore_req` or `pwr_up`) holds `busy` high for exactly RESTORE_CYC cycles. It leaves the array equal to the shadow and does not change the shadow. Reads and writes made while `busy` is high produce no `rvalid` and change nothing.
- R8: A `save_req` pulse while idle holds `busy` high for exactly SAVE_CYC cycles and copies the array and `auto_en` into the shadow.
- R9: While `low_vdd` is 1, write accesses leave the array unchanged and `save_req` starts no save.
- R10: If `ce_n` and `we_n` are both 0 at the end of a save or restore (or at reset), writes are ignored until a falling edge of `ce_n` or `we_n`. The write carried by that falling edge is accepted.
- R11: A read is an access with `ce_n`=0, `we_n`=1 and `oe_n`=0. Its data appears on `rdata` with `rvalid`=1 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset, also the factory initialisation |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | AW | Word address |
| wdata | input | DW | Write data |
| low_vdd | input | 1 | Low-supply indication |
| save_req | input | 1 | Manual save request, one-cycle pulse |
| restore_req | input | 1 | Restore request, one-cycle pulse |
| pwr_up | input | 1 | Power-up event, one-cycle pulse |
| rdata | output | DW | Read data |
| rvalid | output | 1 | Read data valid |
| busy | output | 1 | Save or restore in progress |
| auto_en | output | 1 | Automatic-save enable flag |

## Verification
A matcher stuck at the wrong stage shows up on `auto_en`. The flag either fails to change in the cycle after a sixth matching read, or it changes after an interrupted run. Either way the error appears within one cycle of the command. A wrong write-lock state or a bad shadow copy does not show on any flag. It appears as stale or wrong data on the next read of the affected word, one cycle after that read. A bad save or restore counter shows as a `busy` pulse of the wrong length, which is visible when `busy` falls.

// File: rtl/nvs_pkg.sv
// Shared constants and types for the nonvolatile SRAM command sequencer.
// Assumes addresses are compared on 16 bits.
package nvs_pkg;

    localparam int SEQ_LEN = 6;

    localparam logic [15:0] LAST_OFF = 16'h8B45;
    localparam logic [15:0] LAST_ON  = 16'h4B46;

    // Address expected at step i (0..SEQ_LEN-2); the final step is LAST_OFF/LAST_ON.
    function automatic logic [15:0] seq_addr(input int unsigned i);
        case (i)
            0:       return 16'h4E38;
            1:       return 16'hB1C7;
            2:       return 16'h83E0;
            3:       return 16'h7C1F;
            4:       return 16'h703F;
            default: return 16'h0000;
        endcase
    endfunction

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_RESTORE = 2'd1,
        ST_SAVE    = 2'd2
    } nvs_state_e;

    typedef enum logic [1:0] {
        CMD_NONE     = 2'd0,
        CMD_AUTO_OFF = 2'd1,
        CMD_AUTO_ON  = 2'd2
    } nvs_cmd_e;

endpackage

// File: rtl/nvs_cmd_match.sv
// Read-address command matcher.
// Tracks progress through the six-read command run. It emits a one-cycle
// command code in the cycle of the sixth matching read.
// Assumes rd_hit and wr_hit are never both high.
module nvs_cmd_match
    import nvs_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rd_hit,
    input  logic        wr_hit,
    input  logic [15:0] addr16,
    output nvs_cmd_e    cmd
);
    localparam int SW = $clog2(SEQ_LEN);
    localparam logic [SW-1:0] LAST_STAGE = SW'(SEQ_LEN - 1);

    logic [SW-1:0]        stage_q;
    logic [SW-1:0]        stage_d;
    logic [SEQ_LEN-2:0]   step_hit;

    // One comparator per fixed step of the run.
    for (genvar i = 0; i < SEQ_LEN - 1; i++) begin : g_step
        assign step_hit[i] = (addr16 == seq_addr(i));
    end

    // Next stage and command decode.
    always_comb begin
        cmd     = CMD_NONE;
        stage_d = stage_q;
        if (wr_hit) begin
            stage_d = '0;
        end else if (rd_hit) begin
            if (stage_q == LAST_STAGE) begin
                if (addr16 == LAST_OFF) begin
                    cmd = CMD_AUTO_OFF;
                end else if (addr16 == LAST_ON) begin
                    cmd = CMD_AUTO_ON;
                end
                stage_d = step_hit[0] ? SW'(1) : '0;
            end else if (step_hit[stage_q]) begin
                stage_d = stage_q + SW'(1);
            end else begin
                stage_d = step_hit[0] ? SW'(1) : '0;
            end
        end
    end

    // Stage register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q <= stage_d;
        end
    end

endmodule

// File: rtl/nvs_wr_gate.sv
// Write lockout gate.
// Locks writes when both enables are low at reset or when an arm pulse
// arrives. Unlocks on a falling edge of either enable. Low supply blocks
// writes at all times.
// Assumes arm is a one-cycle pulse at the end of a save or restore.
module nvs_wr_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic ce_n,
    input  logic we_n,
    input  logic arm,
    input  logic low_vdd,
    output logic wr_ok
);
    logic ce_prev;
    logic we_prev;
    logic lock_q;
    logic fall;

    assign fall  = (ce_prev && !ce_n) || (we_prev && !we_n);
    assign wr_ok = !low_vdd && (!lock_q || fall);

    // Enable history and lock state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ce_prev <= ce_n;
            we_prev <= we_n;
            lock_q  <= !ce_n && !we_n;
        end else begin
            ce_prev <= ce_n;
            we_prev <= we_n;
            if (arm) begin
                lock_q <= !ce_n && !we_n;
            end else if (fall) begin
                lock_q <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/nvs_store.sv
// Register model of the SRAM array and its nonvolatile shadow.
// Word writes, a whole-array clear, shadow-to-array load and
// array-to-shadow copy. The read port is combinational.
// Assumes at most one of clear_arr, load_arr and wr_en is high per cycle.
module nvs_store #(
    parameter int DW    = 8,
    parameter int DEPTH = 64,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [DW-1:0] wr_data,
    input  logic [IW-1:0] rd_idx,
    input  logic          clear_arr,
    input  logic          load_arr,
    input  logic          save_arr,
    output logic [DW-1:0] rd_data
);
    logic [DW-1:0] arr_w [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_word
        logic [DW-1:0] word_q;
        logic [DW-1:0] shadow_q;

        // Array word: clear, load, then host write, in that priority.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                word_q <= '0;
            end else if (clear_arr) begin
                word_q <= '0;
            end else if (load_arr) begin
                word_q <= shadow_q;
            end else if (wr_en && (wr_idx == IW'(g))) begin
                word_q <= wr_data;
            end
        end

        // Shadow word: changes only on a save.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                shadow_q <= '0;
            end else if (save_arr) begin
                shadow_q <= word_q;
            end
        end

        assign arr_w[g] = word_q;
    end

    assign rd_data = arr_w[rd_idx];

endmodule

// File: rtl/nvs_seq_top.sv
// Nonvolatile SRAM command sequencer, top level.
// Samples the host bus once per clock. Runs save and restore cycles,
// keeps the automatic-save flag and its shadow copy, and routes reads
// and writes to the store.
// Assumes AW >= 16 and that request inputs are one-cycle pulses.
module nvs_seq_top
    import nvs_pkg::*;
#(
    parameter int AW          = 16,
    parameter int DW          = 8,
    parameter int DEPTH       = 64,
    parameter int RESTORE_CYC = 8,
    parameter int SAVE_CYC    = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce_n,
    input  logic          we_n,
    input  logic          oe_n,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic          low_vdd,
    input  logic          save_req,
    input  logic          restore_req,
    input  logic          pwr_up,
    output logic [DW-1:0] rdata,
    output logic          rvalid,
    output logic          busy,
    output logic          auto_en
);
    localparam int IW     = $clog2(DEPTH);
    localparam int MAXCYC = (RESTORE_CYC > SAVE_CYC) ? RESTORE_CYC : SAVE_CYC;
    localparam int CW     = $clog2(MAXCYC + 1);

    nvs_state_e    st_q;
    logic [CW-1:0] cnt_q;
    logic          shadow_auto_q;
    logic          idle;
    logic          go_restore;
    logic          go_save;
    logic          acc;
    logic          rd_acc;
    logic          wr_try;
    logic          wr_ok;
    logic          wr_en;
    logic          done;
    logic          load_arr;
    logic          save_arr;
    nvs_cmd_e      cmd;
    logic [DW-1:0] store_rd;

    assign idle       = (st_q == ST_IDLE);
    assign go_restore = idle && (pwr_up || restore_req);
    assign go_save    = idle && !go_restore && save_req && !low_vdd;
    assign acc        = idle && !go_restore && !go_save && !ce_n;
    assign rd_acc     = acc && we_n && !oe_n;
    assign wr_try     = acc && !we_n;
    assign wr_en      = wr_try && wr_ok;
    assign done       = !idle && (cnt_q == '0);
    assign load_arr   = done && (st_q == ST_RESTORE);
    assign save_arr   = done && (st_q == ST_SAVE);
    assign busy       = !idle;

    // Save and restore sequencing with a cycle counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
        end else if (go_restore) begin
            st_q  <= ST_RESTORE;
            cnt_q <= CW'(RESTORE_CYC - 1);
        end else if (go_save) begin
            st_q  <= ST_SAVE;
            cnt_q <= CW'(SAVE_CYC - 1);
        end else if (!idle) begin
            if (cnt_q == '0) begin
                st_q <= ST_IDLE;
            end else begin
                cnt_q <= cnt_q - CW'(1);
            end
        end
    end

    // Automatic-save flag: power-up reload first, then commands.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            auto_en <= 1'b1;
        end else if (go_restore && pwr_up) begin
            auto_en <= shadow_auto_q;
        end else if (cmd == CMD_AUTO_OFF) begin
            auto_en <= 1'b0;
        end else if (cmd == CMD_AUTO_ON) begin
            auto_en <= 1'b1;
        end
    end

    // Shadow copy of the flag, written only by a completed save.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow_auto_q <= 1'b1;
        end else if (save_arr) begin
            shadow_auto_q <= auto_en;
        end
    end

    // Registered read return.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rvalid <= 1'b0;
            rdata  <= '0;
        end else begin
            rvalid <= rd_acc;
            if (rd_acc) begin
                rdata <= store_rd;
            end
        end
    end

    nvs_cmd_match u_match (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_hit (rd_acc),
        .wr_hit (wr_try),
        .addr16 (addr[15:0]),
        .cmd    (cmd)
    );

    nvs_wr_gate u_gate (
        .clk     (clk),
        .rst_n   (rst_n),
        .ce_n    (ce_n),
        .we_n    (we_n),
        .arm     (done),
        .low_vdd (low_vdd),
        .wr_ok   (wr_ok)
    );

    nvs_store #(
        .DW    (DW),
        .DEPTH (DEPTH)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_idx    (addr[IW-1:0]),
        .wr_data   (wdata),
        .rd_idx    (addr[IW-1:0]),
        .clear_arr (go_restore),
        .load_arr  (load_arr),
        .save_arr  (save_arr),
        .rd_data   (store_rd)
    );

endmodule

// File: rtl/nvs_seq_chk.sv
// Port-level property checker for nvs_seq_top, attached by bind.
// Assumes the bound instance's parameters are passed through.
module nvs_seq_chk #(
    parameter int RESTORE_CYC = 8,
    parameter int SAVE_CYC    = 6
) (
    input logic clk,
    input logic rst_n,
    input logic ce_n,
    input logic we_n,
    input logic oe_n,
    input logic low_vdd,
    input logic save_req,
    input logic restore_req,
    input logic pwr_up,
    input logic rvalid,
    input logic busy,
    input logic auto_en
);
    logic [15:0] blen_q;

    // Length of the current busy window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            blen_q <= '0;
        end else if (busy) begin
            blen_q <= blen_q + 16'd1;
        end else begin
            blen_q <= '0;
        end
    end

    // R7 and R8: a busy window lasts exactly one of the two configured lengths.
    a_r7_busy_len: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (blen_q == 16'(RESTORE_CYC) || blen_q == 16'(SAVE_CYC)));

    // R9: a save request under low supply starts nothing.
    a_r9_no_save_low: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && low_vdd && save_req && !restore_req && !pwr_up) |=> !busy);

    // R7: no read data while busy.
    a_r7_no_read_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !rvalid);

    // R11: read data only follows a read access.
    a_r11_rvalid_src: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |-> $past(!ce_n && we_n && !oe_n));

    // R2: the flag falls only after a read or a power-up reload.
    a_r2_off_source: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(auto_en) |-> ($past(pwr_up) || $past(!ce_n && we_n && !oe_n)));

    // R3: the flag rises only after a read or a power-up reload.
    a_r3_on_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(auto_en) |-> ($past(pwr_up) || $past(!ce_n && we_n && !oe_n)));

endmodule

bind nvs_seq_top nvs_seq_chk #(
    .RESTORE_CYC (RESTORE_CYC),
    .SAVE_CYC    (SAVE_CYC)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ce_n        (ce_n),
    .we_n        (we_n),
    .oe_n        (oe_n),
    .low_vdd     (low_vdd),
    .save_req    (save_req),
    .restore_req (restore_req),
    .pwr_up      (pwr_up),
    .rvalid      (rvalid),
    .busy        (busy),
    .auto_en     (auto_en)
);

// File: tb/tb_nvs_seq_top.sv
// Scoreboard bench for nvs_seq_top.
module tb_nvs_seq_top;
    localparam int AW = 18;
    localparam int DW = 8;
    localparam int DEPTH = 64;
    localparam int RCYC = 8;
    localparam int SCYC = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic low_vdd = 1'b0, save_req = 1'b0, restore_req = 1'b0, pwr_up = 1'b0;
    logic [DW-1:0] rdata;
    logic rvalid, busy, auto_en;

    int n_chk = 0;
    int n_fail = 0;

    logic [DW-1:0] mem_m [DEPTH];
    logic [DW-1:0] shd_m [DEPTH];
    logic [DW-1:0] exp_q [$];
    string         tag_q [$];

    localparam logic [15:0] STEP [5] = '{16'h4E38, 16'hB1C7, 16'h83E0, 16'h7C1F, 16'h703F};
    localparam logic [15:0] OFF6 = 16'h8B45;
    localparam logic [15:0] ON6  = 16'h4B46;

    always #2.5 clk = ~clk;

    nvs_seq_top #(.AW(AW), .DW(DW), .DEPTH(DEPTH), .RESTORE_CYC(RCYC), .SAVE_CYC(SCYC)) dut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .wdata(wdata), .low_vdd(low_vdd), .save_req(save_req),
        .restore_req(restore_req), .pwr_up(pwr_up), .rdata(rdata),
        .rvalid(rvalid), .busy(busy), .auto_en(auto_en)
    );

    task automatic check(string tag, int act, int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Monitor: compare every returned read against the scoreboard.
    always @(negedge clk) begin
        if (rst_n && rvalid) begin
            if (exp_q.size() == 0) begin
                n_chk++;
                n_fail++;
                $display("FAIL R7: unexpected read data actual %0h expected none", rdata);
            end else begin
                logic [DW-1:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(t, int'(rdata), int'(e));
            end
        end
    end

    task automatic bus(logic c, logic w, logic o, logic [AW-1:0] a, logic [DW-1:0] d);
        ce_n = c; we_n = w; oe_n = o; addr = a; wdata = d;
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        bus(1'b1, 1'b1, 1'b1, '0, '0);
    endtask

    task automatic rd(logic [AW-1:0] a, string tag);
        exp_q.push_back(mem_m[a[5:0]]);
        tag_q.push_back(tag);
        bus(1'b0, 1'b1, 1'b0, a, '0);
    endtask

    task automatic rd_ignored(logic [AW-1:0] a);
        bus(1'b0, 1'b1, 1'b0, a, '0);
    endtask

    task automatic wr(logic [AW-1:0] a, logic [DW-1:0] d, bit takes);
        bus(1'b0, 1'b0, 1'b1, a, d);
        if (takes) mem_m[a[5:0]] = d;
    endtask

    task automatic run_seq(logic [15:0] last, logic [1:0] hi, string tag);
        for (int i = 0; i < 5; i++) rd({hi, STEP[i]}, tag);
        rd({hi, last}, tag);
    endtask

    task automatic pulse(int which);
        if (which == 0) save_req = 1'b1;
        else if (which == 1) restore_req = 1'b1;
        else pwr_up = 1'b1;
        @(posedge clk);
        #1;
        save_req = 1'b0; restore_req = 1'b0; pwr_up = 1'b0;
    endtask

    task automatic count_busy(int start, string tag, int exp);
        int n = start;
        forever begin
            @(negedge clk);
            if (busy) n++;
            else break;
        end
        check(tag, n, exp);
    endtask

    task automatic flag_is(string tag, logic exp);
        @(negedge clk);
        check(tag, int'(auto_en), int'(exp));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) begin
            mem_m[i] = '0;
            shd_m[i] = '0;
        end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check("R1 auto_en", int'(auto_en), 1);
        check("R1 busy", int'(busy), 0);
        check("R1 rvalid", int'(rvalid), 0);
        @(posedge clk); #1;
        rd(18'd5, "R1 array zero");

        // R11: plain write then read back.
        wr(18'd3, 8'hA5, 1);
        wr(18'h38, 8'h11, 1);
        wr(18'h3F, 8'h5A, 1);
        idle();
        rd(18'd3, "R11 read");
        rd(18'h3F, "R11 read");
        idle();

        // R2: disable run; matched reads return array data.
        run_seq(OFF6, 2'b00, "R2 data");
        idle();
        flag_is("R2 off", 1'b0);

        // R4: mismatch at 0x4E38 restarts as step one, run completes.
        rd({2'b00, STEP[0]}, "R4 data");
        rd({2'b00, STEP[1]}, "R4 data");
        rd({2'b00, STEP[2]}, "R4 data");
        run_seq(ON6, 2'b00, "R4 data");
        idle();
        flag_is("R4 restart", 1'b1);

        // R4: a write in the middle aborts the run.
        rd({2'b00, STEP[0]}, "R4 data");
        rd({2'b00, STEP[1]}, "R4 data");
        rd({2'b00, STEP[2]}, "R4 data");
        wr(18'h10, 8'h22, 1);
        rd({2'b00, STEP[3]}, "R4 data");
        rd({2'b00, STEP[4]}, "R4 data");
        rd({2'b00, OFF6}, "R4 data");
        idle();
        flag_is("R4 write abort", 1'b1);

        // R5: upper address bits are ignored by the matcher.
        run_seq(OFF6, 2'b11, "R5 data");
        idle();
        flag_is("R5 high bits", 1'b0);

        // R3: enable run.
        run_seq(ON6, 2'b00, "R3 data");
        idle();
        flag_is("R3 on", 1'b1);

        // R8: disable, then save array and flag.
        run_seq(OFF6, 2'b00, "R2 data");
        idle();
        pulse(0);
        count_busy(0, "R8 save busy", SCYC);
        for (int i = 0; i < DEPTH; i++) shd_m[i] = mem_m[i];
        @(posedge clk); #1;
        wr(18'd3, 8'h77, 1);
        idle();
        run_seq(ON6, 2'b00, "R3 data");
        idle();
        flag_is("R3 on volatile", 1'b1);

        // R6/R7: power-up restore; accesses while busy are ignored.
        @(posedge clk); #1;
        pulse(2);
        rd_ignored(18'd3);
        wr(18'd3, 8'hEE, 0);
        idle();
        count_busy(3, "R7 restore busy", RCYC);
        for (int i = 0; i < DEPTH; i++) mem_m[i] = shd_m[i];
        check("R6 flag reload", int'(auto_en), 0);
        @(posedge clk); #1;
        rd(18'd3, "R7 array from shadow");
        rd(18'h10, "R7 array from shadow");
        idle();

        // R7: restore leaves the shadow unchanged.
        wr(18'd3, 8'h99, 1);
        idle();
        pulse(1);
        count_busy(0, "R7 restore busy", RCYC);
        for (int i = 0; i < DEPTH; i++) mem_m[i] = shd_m[i];
        @(posedge clk); #1;
        rd(18'd3, "R7 shadow kept");
        idle();

        // R9: low supply blocks writes and saves.
        low_vdd = 1'b1;
        wr(18'd3, 8'h12, 0);
        idle();
        rd(18'd3, "R9 write blocked");
        idle();
        pulse(0);
        @(negedge clk);
        check("R9 save blocked", int'(busy), 0);
        @(posedge clk); #1;
        low_vdd = 1'b0;
        idle();
        wr(18'd3, 8'h12, 1);
        idle();
        rd(18'd3, "R9 write after recovery");
        idle();

        // R10: both enables low at end of restore lock writes until a fall.
        pulse(1);
        ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1; addr = 18'd10; wdata = 8'h33;
        count_busy(0, "R7 restore busy", RCYC);
        for (int i = 0; i < DEPTH; i++) mem_m[i] = shd_m[i];
        @(posedge clk); #1;
        @(posedge clk); #1;
        rd(18'd10, "R10 locked write ignored");
        wr(18'd10, 8'h44, 1);
        rd(18'd10, "R10 write after fall");
        idle();

        repeat (3) idle();
        check("R11 scoreboard drained", exp_q.size(), 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule